// File: doc/BRIEF.md
# Configurable Simple Dual-Port RAM

A word-addressed memory with one write side (address, data, per-byte enables, write strobe) and one read side (address, read strobe, data out). Each path into and out of the array is set at elaboration time to be either combinational or held in a register. A registered path runs on the write clock or on the read clock, and each such register is independently chosen to respond to, or ignore, a shared asynchronous clear.

When the read address is registered on the write clock, the two sides share one timing domain. A parameter then decides what a read returns when it hits a word whose write is being committed in the same cycle: the freshly written bytes, the prior contents, or whatever is convenient (unspecified). Writes may be limited to selected byte lanes. The word count may be smaller than the address space. Addresses beyond it are inert.

Top module: `dpram_cfg`

## Requirements
- R1: Addresses at or above the `WORDS` parameter are outside the array: a write there changes no word and a read there yields zero; address `WORDS-1` is an ordinary word.
- R2: A word changes only on a write-clock edge where the effective write strobe is high. With registered write inputs the commit happens on the write-clock edge after the one that captured them; with combinational write inputs it happens on the capturing edge itself.
- R3: With byte enables in use, lane i is bits `[i*BYTE +: BYTE]` of the word and `be[i]=1` marks it to be written. Lanes whose bit is 0 keep their contents, and an all-zero mask changes nothing. Without byte enables, `be` is one bit and is ignored.
- R4: Every registered read-side stage adds exactly one cycle of its clock. With registered read address, registered read strobe and registered output, data for a read presented before edge k is on `q` after edge k+1, and back-to-back reads stream one word per cycle.
- R5: A registered read-address stage loads only when `re` is high at that edge, and a registered output stage loads only when the effective read strobe is high; otherwise each keeps its value.
- R6: In mode `RDW=2`, with the read address registered on the write clock, a read of the word whose write is pending in that cycle returns the prior word with the enabled lanes replaced by the new data.
- R7: In mode `RDW=1`, the same collision returns the prior contents of the word. Mode `RDW=0` leaves the result unspecified.
- R8: Raising `aclr` immediately zeroes every path register whose clear-enable parameter is 1. Registers whose clear-enable is 0 keep their value through the clear.
- R9: The array holds zeros at power-up, and the asynchronous clear leaves stored words untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (input) clock |
| rclk | input | 1 | Read-side (output) clock |
| aclr | input | 1 | Asynchronous clear for the path registers that opt in |
| waddr | input | AW | Write word address |
| wdata | input | DW | Write data |
| be | input | BEW | Byte-lane write mask (BEW = DW/BYTE, or 1 without byte enables) |
| we | input | 1 | Write strobe |
| raddr | input | AW | Read word address |
| re | input | 1 | Read strobe |
| q | output | DW | Read data |

## Verification
The bench targets a read that collides with a pending write. It runs two copies side by side, one per defined collision mode. A wrong bypass would show stale data on the new-data copy or leak new bytes into the old-data copy. Partial and empty byte masks are checked next, since a design that ignores the mask would overwrite neighbouring lanes. The bench also covers an address just past the word count, where a missing range check would alias a real word. It covers idle read strobes, where a free-running output register would let `q` drift. Last, it pulses the clear between reads, which exposes a clear that wipes the array or ignores the per-register clear enable.

// File: rtl/dpram_cfg.sv
module dpram_cfg #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int WORDS  = 2 ** AW,
  parameter int BYTE   = 8,
  parameter int USE_BE = 1,
  localparam int BEW   = (USE_BE != 0) ? DW / BYTE : 1,
  localparam int LANE  = (USE_BE != 0) ? BYTE : DW,
  parameter int WA_SRC = 1,
  parameter int WE_SRC = 1,
  parameter int WD_SRC = 1,
  parameter int RA_SRC = 2,
  parameter int RE_SRC = 2,
  parameter int Q_SRC  = 0,
  parameter bit WA_CLR = 1'b1,
  parameter bit WE_CLR = 1'b1,
  parameter bit WD_CLR = 1'b1,
  parameter bit RA_CLR = 1'b1,
  parameter bit RE_CLR = 1'b1,
  parameter bit Q_CLR  = 1'b1,
  parameter int RDW    = 2
) (
  input  logic           wclk,
  input  logic           rclk,
  input  logic           aclr,
  input  logic [AW-1:0]  waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [BEW-1:0] be,
  input  logic           we,
  input  logic [AW-1:0]  raddr,
  input  logic           re,
  output logic [DW-1:0]  q
);

  logic [AW-1:0]  wa_e, ra_e;
  logic [DW-1:0]  wd_e, rd_core, stored;
  logic [BEW-1:0] be_i, be_e;
  logic           we_e, re_e, hit;
  logic [DW-1:0]  mem [WORDS];

  wire ra_clk = (RA_SRC == 2) ? rclk : wclk;
  wire re_clk = (RE_SRC == 2) ? rclk : wclk;

  assign be_i = (USE_BE != 0) ? be : {BEW{1'b1}};

  initial for (int i = 0; i < WORDS; i++) mem[i] = '0;

  if (WA_SRC == 0) begin : g_wa_c
    assign wa_e = waddr;
  end else begin : g_wa_r
    logic [AW-1:0] r;
    wire clr = aclr & WA_CLR;
    always_ff @(posedge wclk or posedge clr)
      if (clr) r <= '0;
      else     r <= waddr;
    assign wa_e = r;
  end

  if (WE_SRC == 0) begin : g_we_c
    assign we_e = we;
    assign be_e = be_i;
  end else begin : g_we_r
    logic           r;
    logic [BEW-1:0] b;
    wire clr = aclr & WE_CLR;
    always_ff @(posedge wclk or posedge clr)
      if (clr) begin
        r <= 1'b0;
        b <= '0;
      end else begin
        r <= we;
        b <= be_i;
      end
    assign we_e = r;
    assign be_e = b;
  end

  if (WD_SRC == 0) begin : g_wd_c
    assign wd_e = wdata;
  end else begin : g_wd_r
    logic [DW-1:0] r;
    wire clr = aclr & WD_CLR;
    always_ff @(posedge wclk or posedge clr)
      if (clr) r <= '0;
      else     r <= wdata;
    assign wd_e = r;
  end

  if (RA_SRC == 0) begin : g_ra_c
    assign ra_e = raddr;
  end else begin : g_ra_r
    logic [AW-1:0] r;
    wire clr = aclr & RA_CLR;
    always_ff @(posedge ra_clk or posedge clr)
      if (clr)     r <= '0;
      else if (re) r <= raddr;
    assign ra_e = r;
  end

  if (RE_SRC == 0) begin : g_re_c
    assign re_e = re;
  end else begin : g_re_r
    logic r;
    wire clr = aclr & RE_CLR;
    always_ff @(posedge re_clk or posedge clr)
      if (clr) r <= 1'b0;
      else     r <= re;
    assign re_e = r;
  end

  always_ff @(posedge wclk)
    if (we_e && int'(wa_e) < WORDS)
      for (int i = 0; i < BEW; i++)
        if (be_e[i]) mem[wa_e][i*LANE +: LANE] <= wd_e[i*LANE +: LANE];

  assign stored = (int'(ra_e) < WORDS) ? mem[ra_e] : '0;
  assign hit = (RDW == 2) && (RA_SRC == 1) && we_e && (wa_e == ra_e) && (int'(ra_e) < WORDS);

  always_comb begin
    rd_core = stored;
    if (hit)
      for (int i = 0; i < BEW; i++)
        if (be_e[i]) rd_core[i*LANE +: LANE] = wd_e[i*LANE +: LANE];
  end

  if (Q_SRC == 0) begin : g_q_c
    assign q = rd_core;
  end else begin : g_q_r
    logic [DW-1:0] r;
    wire clr = aclr & Q_CLR;
    always_ff @(posedge rclk or posedge clr)
      if (clr)       r <= '0;
      else if (re_e) r <= rd_core;
    assign q = r;
  end

endmodule

module dpram_cfg_chk #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int WORDS  = 16,
  parameter int LANE   = 8,
  parameter int BEW    = 2,
  parameter int RA_SRC = 2,
  parameter int Q_SRC  = 0,
  parameter bit Q_CLR  = 1'b1,
  parameter int RDW    = 2
) (
  input logic           wclk,
  input logic           rclk,
  input logic           aclr,
  input logic [AW-1:0]  wa_e,
  input logic [AW-1:0]  ra_e,
  input logic [DW-1:0]  wd_e,
  input logic [BEW-1:0] be_e,
  input logic           we_e,
  input logic           re_e,
  input logic [DW-1:0]  rd_core,
  input logic [DW-1:0]  q,
  input logic [DW-1:0]  mem [WORDS]
);

  logic armed_w, armed_r, full_d, keep_d;
  logic [AW-1:0]   wa_d;
  logic [DW-1:0]   wd_d;
  logic [LANE-1:0] lane0_d;
  wire in_rng = int'(wa_e) < WORDS;

  always_ff @(posedge wclk or posedge aclr)
    if (aclr) armed_w <= 1'b0;
    else      armed_w <= 1'b1;

  always_ff @(posedge rclk or posedge aclr)
    if (aclr) armed_r <= 1'b0;
    else      armed_r <= 1'b1;

  always_ff @(posedge wclk) begin
    full_d  <= we_e && in_rng && (&be_e);
    keep_d  <= we_e && in_rng && !be_e[0];
    wa_d    <= wa_e;
    wd_d    <= wd_e;
    lane0_d <= in_rng ? mem[wa_e][LANE-1:0] : '0;
  end

  assert_oob_zero_R1: assert property (@(posedge rclk) disable iff (aclr)
    (int'(ra_e) >= WORDS) |-> rd_core == '0);

  assert_full_write_R2: assert property (@(posedge wclk) disable iff (aclr || !armed_w)
    full_d |-> mem[wa_d] == wd_d);

  assert_lane_kept_R3: assert property (@(posedge wclk) disable iff (aclr || !armed_w)
    keep_d |-> mem[wa_d][LANE-1:0] == lane0_d);

  if (Q_SRC != 0) begin : g_qchk
    assert_q_hold_R5: assert property (@(posedge rclk) disable iff (aclr || !armed_r)
      !re_e |=> $stable(q));
    if (Q_CLR) begin : g_clr
      assert_q_clear_R8: assert property (@(posedge rclk) aclr |-> q == '0);
    end
  end

  if (RDW == 2 && RA_SRC == 1) begin : g_new
    assert_new_data_R6: assert property (@(posedge wclk) disable iff (aclr || !armed_w)
      (we_e && wa_e == ra_e && in_rng && (&be_e)) |-> rd_core == wd_e);
  end

endmodule

bind dpram_cfg dpram_cfg_chk #(
  .DW(DW), .AW(AW), .WORDS(WORDS), .LANE(LANE), .BEW(BEW),
  .RA_SRC(RA_SRC), .Q_SRC(Q_SRC), .Q_CLR(Q_CLR), .RDW(RDW)
) u_chk (
  .wclk(wclk), .rclk(rclk), .aclr(aclr), .wa_e(wa_e), .ra_e(ra_e),
  .wd_e(wd_e), .be_e(be_e), .we_e(we_e), .re_e(re_e), .rd_core(rd_core),
  .q(q), .mem(mem)
);

// File: tb/sim_dpram_cfg.sv
module sim_dpram_cfg;
  localparam int DW = 16, AW = 4, WORDS = 12;

  logic clk = 1'b0, aclr = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0, q0, q1;
  logic [1:0]    be = '0;
  logic          we = 1'b0, re = 1'b0;

  dpram_cfg #(.DW(DW), .AW(AW), .WORDS(WORDS), .BYTE(8), .USE_BE(1),
              .RA_SRC(1), .RE_SRC(1), .Q_SRC(2), .RDW(2)) u0 (
    .wclk(clk), .rclk(clk), .aclr(aclr), .waddr(waddr), .wdata(wdata), .be(be),
    .we(we), .raddr(raddr), .re(re), .q(q0));

  dpram_cfg #(.DW(DW), .AW(AW), .WORDS(WORDS), .BYTE(8), .USE_BE(1),
              .RA_SRC(1), .RE_SRC(1), .Q_SRC(2), .Q_CLR(1'b0), .RDW(1)) u1 (
    .wclk(clk), .rclk(clk), .aclr(aclr), .waddr(waddr), .wdata(wdata), .be(be),
    .we(we), .raddr(raddr), .re(re), .q(q1));

  typedef struct {
    int            due;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
    string         tag;
  } item_t;

  item_t         sb[$];
  int            cyc = 0, checks = 0, errors = 0;
  logic [DW-1:0] model [WORDS];
  logic [DW-1:0] last0 = '0, last1 = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string who, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, who, act, exp);
    end
  endtask

  always @(negedge clk)
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, "u0", q0, it.e0);
      check(it.tag, "u1", q1, it.e1);
    end

  task automatic op(bit w, int wa, logic [DW-1:0] wd, logic [1:0] b, bit r, int ra, string tag);
    item_t it;
    logic [DW-1:0] old, nw;
    @(negedge clk);
    we = w; waddr = wa[AW-1:0]; wdata = wd; be = b; re = r; raddr = ra[AW-1:0];
    if (r) begin
      old = (ra < WORDS) ? model[ra] : '0;
      nw  = old;
      if (w && wa == ra && ra < WORDS)
        for (int i = 0; i < 2; i++) if (b[i]) nw[i*8 +: 8] = wd[i*8 +: 8];
      last0 = nw;
      last1 = old;
    end
    it = '{cyc + 2, last0, last1, tag};
    sb.push_back(it);
    if (w && wa < WORDS)
      for (int i = 0; i < 2; i++) if (b[i]) model[wa][i*8 +: 8] = wd[i*8 +: 8];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    #2 aclr = 1'b1;
    #1 check("R8 reset", "u0", q0, '0);
    @(negedge clk); @(negedge clk);
    aclr = 1'b0;

    op(0, 0, 16'h0, 2'b00, 1, 5, "R9 power-up zero");
    op(1, 3, 16'h1234, 2'b11, 0, 0, "R5 idle hold");
    op(0, 0, 16'h0, 2'b00, 1, 3, "R2 write lands");
    op(1, 3, 16'hABCD, 2'b01, 1, 3, "R6/R7 collision");
    op(0, 0, 16'h0, 2'b00, 1, 3, "R3 low lane only");
    op(1, 3, 16'h5500, 2'b10, 1, 3, "R6/R7 high lane collision");
    op(0, 0, 16'h0, 2'b00, 1, 3, "R3 high lane only");
    op(1, 7, 16'hFFFF, 2'b00, 0, 0, "R5 idle hold");
    op(0, 0, 16'h0, 2'b00, 1, 7, "R3 empty mask");
    op(0, 8, 16'hEEEE, 2'b11, 1, 8, "R2 no strobe");
    op(0, 0, 16'h0, 2'b00, 1, 8, "R2 no strobe");
    op(1, 13, 16'h7777, 2'b11, 0, 0, "R5 idle hold");
    op(1, 11, 16'h2468, 2'b11, 1, 13, "R1 out of range");
    op(0, 0, 16'h0, 2'b00, 1, 11, "R1 last word");
    op(1, 12, 16'h9999, 2'b11, 1, 12, "R1 boundary collision");
    op(0, 0, 16'h0, 2'b00, 1, 3, "R4 read");
    op(0, 0, 16'h0, 2'b00, 0, 11, "R5 hold with new address");
    op(0, 0, 16'h0, 2'b00, 0, 5, "R5 hold with new address");
    for (int i = 0; i < WORDS; i++)
      op(1, i, 16'h1000 + 16'(i) * 16'h0111, 2'b11, 0, 0, "R5 idle hold");
    for (int i = 0; i < WORDS; i++)
      op(0, 0, 16'h0, 2'b00, 1, i, "R4 streaming read");
    op(0, 0, 16'h0, 2'b00, 0, 0, "R5 idle hold");
    op(0, 0, 16'h0, 2'b00, 0, 0, "R5 idle hold");
    wait (sb.size() == 0);
    @(negedge clk);

    aclr = 1'b1;
    #1;
    check("R8 cleared q", "u0", q0, '0);
    check("R8 clear disabled keeps q", "u1", q1, last1);
    @(negedge clk);
    aclr = 1'b0;
    last0 = '0;
    op(0, 0, 16'h0, 2'b00, 1, 4, "R9 contents survive clear");
    op(0, 0, 16'h0, 2'b00, 1, 11, "R9 contents survive clear");
    op(0, 0, 16'h0, 2'b00, 0, 0, "R5 idle hold");
    wait (sb.size() == 0);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule